// File: doc/BRIEF.md
# Packed Halfword Saturating Add/Subtract Unit

This unit executes one packed-halfword arithmetic instruction per cycle. Each 32-bit operand holds two signed 16-bit lanes. The lanes are added or subtracted, either straight or with the two halves of the second operand exchanged. Each lane result is clamped to the signed 16-bit range on its own, and the two lanes are packed back into one 32-bit word.

The unit decodes a 32-bit instruction word. The source register indices are sent out at once, so the surrounding pipeline can read the register file. The operand values come back on the same cycle. The block registers three things on a valid strobe:
- the result,
- the destination index,
- a write enable, gated by the condition field and an external condition-pass input.

Register file storage, flag evaluation and sticky saturation flags stay outside.

Top module: `hsat_addsub`

## Requirements
- R1: The low lane is bits 15:0 and the high lane is bits 31:16 of every operand and of the result. Operation code 0 gives low = n_lo + m_lo and high = n_hi + m_hi.
- R2: Operation code 1 gives low = n_lo - m_hi and high = n_hi + m_lo.
- R3: Operation code 2 gives low = n_lo + m_hi and high = n_hi - m_lo.
- R4: Operation code 3 gives low = n_lo - m_lo and high = n_hi - m_hi.
- R5: Each lane saturates independently of the other. Results above 0x7FFF become 0x7FFF, and results below -0x8000 become 0x8000.
- R6: The instruction fields are: condition in bits 31:28, first source index in bits 19:16, destination index in bits 15:12, operation code in bits 7:5, second source index in bits 3:0. Both source indices appear combinationally on rn_idx_o and rm_idx_o.
- R7: A condition field of 0xE always produces a write. Any other condition value produces a write only when cond_pass_i is high. On a failed condition, wr_en_o stays low but result_o still carries the computed value.
- R8: Operation codes 4 to 7 produce result_o = 0 with wr_en_o low, whatever the condition.
- R9: result_o and rd_idx_o are captured on a rising edge where valid_i is high, and they hold otherwise. valid_o and wr_en_o are high only in the cycle after an accepted valid_i.
- R10: While rst_ni is low, valid_o, wr_en_o, rd_idx_o and result_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction and operands valid this cycle |
| instr_i | input | 32 | Instruction word |
| cond_pass_i | input | 1 | External condition evaluation result |
| rn_data_i | input | 32 | Value of the first source register |
| rm_data_i | input | 32 | Value of the second source register |
| rn_idx_o | output | 4 | Decoded first source index (combinational) |
| rm_idx_o | output | 4 | Decoded second source index (combinational) |
| valid_o | output | 1 | Registered result valid |
| wr_en_o | output | 1 | Registered register-file write enable |
| rd_idx_o | output | 4 | Registered destination index |
| result_o | output | 32 | Registered packed saturated result |

## Verification
The assertions assume three things about the inputs:
- instr_i, cond_pass_i and both operand buses are stable and known whenever valid_i is sampled high.
- The operands belong to the instruction presented in the same cycle.
- The bench drives all inputs at the falling edge.

The random stimulus is mixed with operand values pinned to 0x7FFF, 0x8000, 0x0000 and 0xFFFF, so both saturation limits are reached in every operation code. Condition and operation codes are drawn across their full range, so the always-execute code, failed conditions and the unused operation codes all occur.

// File: rtl/hsat_pkg.sv
package hsat_pkg;
  localparam int WORD_W    = 32;
  localparam int LANE_W    = WORD_W / 2;
  localparam int NUM_LANES = WORD_W / LANE_W;
  localparam int IDX_W     = 4;
  localparam int OP_W      = 3;
  localparam int COND_W    = 4;
  // field positions fixed by the instruction encoding
  localparam int COND_LSB  = 28;
  localparam int RN_LSB    = 16;
  localparam int RD_LSB    = 12;
  localparam int OP_LSB    = 5;
  localparam int RM_LSB    = 0;
  localparam logic [COND_W-1:0] COND_ALWAYS = 4'hE;

  typedef struct packed {
    logic [COND_W-1:0] cond;
    logic [IDX_W-1:0]  rn;
    logic [IDX_W-1:0]  rd;
    logic [IDX_W-1:0]  rm;
    logic [OP_W-1:0]   op;
  } dec_t;
endpackage

// File: rtl/hsat_decode.sv
module hsat_decode
  import hsat_pkg::*;
(
  input  logic [WORD_W-1:0] instr_i,
  output dec_t              dec_o
);
  always_comb begin
    dec_o.cond = instr_i[COND_LSB +: COND_W];
    dec_o.rn   = instr_i[RN_LSB   +: IDX_W];
    dec_o.rd   = instr_i[RD_LSB   +: IDX_W];
    dec_o.rm   = instr_i[RM_LSB   +: IDX_W];
    dec_o.op   = instr_i[OP_LSB   +: OP_W];
  end
endmodule

// File: rtl/hsat_lane.sv
module hsat_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o
);
  logic [W:0] a_x, b_x, sum;
  logic       ovf;

  always_comb begin
    a_x = {a_i[W-1], a_i};
    b_x = {b_i[W-1], b_i};
    sum = sub_i ? (a_x - b_x) : (a_x + b_x);
    ovf = sum[W] ^ sum[W-1];
    // clamp toward the sign of the exact W+1 bit result
    res_o = ovf ? {sum[W], {(W-1){~sum[W]}}} : sum[W-1:0];
  end

  always_comb begin
    if (!sub_i && !a_i[W-1] && !b_i[W-1])
      a_r5_pos_sum_nonneg: assert (!res_o[W-1]);
    if (!sub_i && a_i[W-1] && b_i[W-1])
      a_r5_neg_sum_neg: assert (res_o[W-1]);
  end
endmodule

// File: rtl/hsat_datapath.sv
module hsat_datapath
  import hsat_pkg::*;
(
  input  logic [WORD_W-1:0] n_i,
  input  logic [WORD_W-1:0] m_i,
  input  logic [OP_W-1:0]   op_i,
  output logic              op_ok_o,
  output logic [WORD_W-1:0] res_o
);
  logic              xchg;
  logic [WORD_W-1:0] lane_res;

  assign op_ok_o = (op_i < OP_W'(4));
  // codes 1 and 2 take the second operand's halves swapped
  assign xchg    = op_i[0] ^ op_i[1];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int SRC_A = g;
    logic [LANE_W-1:0] b_sel;
    assign b_sel = xchg ? m_i[(NUM_LANES-1-g)*LANE_W +: LANE_W]
                        : m_i[g*LANE_W +: LANE_W];
    hsat_lane #(.W(LANE_W)) u_lane (
      .a_i   (n_i[SRC_A*LANE_W +: LANE_W]),
      .b_i   (b_sel),
      .sub_i (op_i[g]),
      .res_o (lane_res[g*LANE_W +: LANE_W])
    );
  end

  assign res_o = op_ok_o ? lane_res : '0;
endmodule

// File: rtl/hsat_addsub.sv
module hsat_addsub
  import hsat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic              cond_pass_i,
  input  logic [31:0]       rn_data_i,
  input  logic [31:0]       rm_data_i,
  output logic [3:0]        rn_idx_o,
  output logic [3:0]        rm_idx_o,
  output logic              valid_o,
  output logic              wr_en_o,
  output logic [3:0]        rd_idx_o,
  output logic [31:0]       result_o
);
  dec_t              dec;
  logic              op_ok;
  logic              exec;
  logic [WORD_W-1:0] dp_res;

  hsat_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  hsat_datapath u_dp (
    .n_i     (rn_data_i),
    .m_i     (rm_data_i),
    .op_i    (dec.op),
    .op_ok_o (op_ok),
    .res_o   (dp_res)
  );

  assign rn_idx_o = dec.rn;
  assign rm_idx_o = dec.rm;
  assign exec     = op_ok && ((dec.cond == COND_ALWAYS) || cond_pass_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      rd_idx_o <= '0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      wr_en_o <= valid_i && exec;
      if (valid_i) begin
        rd_idx_o <= dec.rd;
        result_o <= dp_res;
      end
    end
  end

  a_r7_always_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[31:28] == 4'hE && instr_i[7:5] < 3'd4 |=> wr_en_o);
  a_r7_fail_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[31:28] != 4'hE && !cond_pass_i |=> !wr_en_o);
  a_r8_bad_op_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && instr_i[7:5] >= 3'd4 |=> !wr_en_o && result_o == '0);
  a_r9_idle_no_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !wr_en_o && $stable(result_o) && $stable(rd_idx_o));
  a_r9_rd_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o && rd_idx_o == $past(instr_i[15:12]));
  a_r9_wr_implies_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> valid_o);
endmodule

// File: tb/tb_hsat_addsub.sv
module tb_hsat_addsub;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        cond_pass_i = 1'b0;
  logic [31:0] rn_data_i = '0;
  logic [31:0] rm_data_i = '0;
  logic [3:0]  rn_idx_o, rm_idx_o, rd_idx_o;
  logic        valid_o, wr_en_o;
  logic [31:0] result_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hsat_addsub dut (.*);

  function automatic logic [15:0] sat16(int v);
    if (v > 32767) return 16'h7FFF;
    if (v < -32768) return 16'h8000;
    return v[15:0];
  endfunction

  function automatic logic [31:0] model(logic [2:0] op, logic [31:0] n, logic [31:0] m);
    int nl, nh, ml, mh, lo, hi;
    nl = int'($signed(n[15:0]));  nh = int'($signed(n[31:16]));
    ml = int'($signed(m[15:0]));  mh = int'($signed(m[31:16]));
    case (op)
      3'd0: begin lo = nl + ml; hi = nh + mh; end
      3'd1: begin lo = nl - mh; hi = nh + ml; end
      3'd2: begin lo = nl + mh; hi = nh - ml; end
      3'd3: begin lo = nl - ml; hi = nh - mh; end
      default: return 32'h0;
    endcase
    return {sat16(hi), sat16(lo)};
  endfunction

  function automatic logic [31:0] mk(logic [3:0] c, logic [3:0] rn, logic [3:0] rd,
                                     logic [2:0] op, logic [3:0] rm, logic [31:0] fill);
    logic [31:0] w;
    w = fill;
    w[31:28] = c; w[19:16] = rn; w[15:12] = rd; w[7:5] = op; w[3:0] = rm;
    return w;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, accept at posedge, check at next negedge
  task automatic issue(string req, logic [31:0] ins, logic cp, logic [31:0] n, logic [31:0] m);
    logic exp_wr;
    valid_i = 1'b1; instr_i = ins; cond_pass_i = cp; rn_data_i = n; rm_data_i = m;
    #1;
    check({req, " R6 rn_idx"}, 32'(rn_idx_o), 32'(ins[19:16]));
    check({req, " R6 rm_idx"}, 32'(rm_idx_o), 32'(ins[3:0]));
    exp_wr = (ins[7:5] < 3'd4) && ((ins[31:28] == 4'hE) || cp);
    @(posedge clk_i); @(negedge clk_i);
    valid_i = 1'b0;
    check({req, " result"}, result_o, model(ins[7:5], n, m));
    check({req, " R7 wr_en"}, 32'(wr_en_o), 32'(exp_wr));
    check({req, " R9 valid"}, 32'(valid_o), 32'd1);
    check({req, " R6 rd_idx"}, 32'(rd_idx_o), 32'(ins[15:12]));
  endtask

  function automatic logic [15:0] pick16();
    case ($urandom % 6)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'h0000;
      3: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    check("R10 valid_o", 32'(valid_o), 0);
    check("R10 wr_en_o", 32'(wr_en_o), 0);
    check("R10 rd_idx_o", 32'(rd_idx_o), 0);
    check("R10 result_o", result_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 plain add, in range
    issue("R1 add", mk(4'hE, 4'd1, 4'd2, 3'd0, 4'd3, 0), 0, 32'h0003_0005, 32'h0004_FFFE);
    check("R1 exact", result_o, 32'h0007_0003);
    // R5 low saturates high, high saturates low, independently
    issue("R5 add sat", mk(4'hE, 4'd1, 4'd2, 3'd0, 4'd3, 0), 0, 32'h8000_7FFF, 32'hFFFF_0001);
    check("R5 exact", result_o, 32'h8000_7FFF);
    // R2 exchanged add/sub
    issue("R2 asx", mk(4'hE, 4'd4, 4'd5, 3'd1, 4'd6, 0), 0, 32'h0010_0020, 32'h0003_0002);
    check("R2 exact", result_o, 32'h0012_001D);
    // R3 exchanged sub/add
    issue("R3 sax", mk(4'hE, 4'd4, 4'd5, 3'd2, 4'd6, 0), 0, 32'h0010_0020, 32'h0003_0002);
    check("R3 exact", result_o, 32'h000E_0023);
    // R4 subtract with both lanes saturating
    issue("R4 sub sat", mk(4'hE, 4'd7, 4'd8, 3'd3, 4'd9, 0), 0, 32'h7FFF_8000, 32'hFFFF_0001);
    check("R4 exact", result_o, 32'h7FFF_8000);
    // R8 unused op code
    issue("R8 op5", mk(4'hE, 4'd1, 4'd1, 3'd5, 4'd1, 0), 1, 32'h1234_5678, 32'h1111_1111);
    check("R8 zero", result_o, 0);
    // R7 failing condition keeps result, no write
    issue("R7 cond fail", mk(4'h0, 4'd1, 4'd3, 3'd0, 4'd2, 0), 0, 32'h0001_0001, 32'h0001_0001);
    check("R7 no write", 32'(wr_en_o), 0);
    issue("R7 cond pass", mk(4'h1, 4'd1, 4'd3, 3'd3, 4'd2, 0), 1, 32'h0001_0001, 32'h0001_0001);
    check("R7 write", 32'(wr_en_o), 1);

    // R9 hold with no valid: stimulus changes, outputs must not
    begin
      logic [31:0] held_res;
      logic [3:0]  held_rd;
      held_res = result_o; held_rd = rd_idx_o;
      instr_i = mk(4'hE, 4'd0, 4'd15, 3'd0, 4'd0, 0);
      rn_data_i = 32'h0101_0101; rm_data_i = 32'h0202_0202; cond_pass_i = 1;
      @(posedge clk_i); @(negedge clk_i);
      check("R9 valid low", 32'(valid_o), 0);
      check("R9 wr low", 32'(wr_en_o), 0);
      check("R9 result held", result_o, held_res);
      check("R9 rd held", 32'(rd_idx_o), 32'(held_rd));
    end

    // random sweep covering R1..R8
    for (int i = 0; i < 400; i++) begin
      logic [31:0] n, m, ins;
      n = {pick16(), pick16()};
      m = {pick16(), pick16()};
      ins = 32'($urandom);
      if ($urandom % 3 == 0) ins[31:28] = 4'hE;
      if ($urandom % 4 != 0) ins[7] = 1'b0;
      issue("R1-R8 rand", ins, 1'($urandom), n, m);
    end

    // R10 asynchronous reset clears outputs mid-run
    valid_i = 1'b1; instr_i = mk(4'hE, 4'd1, 4'd9, 3'd0, 4'd1, 0);
    rn_data_i = 32'h0001_0001; rm_data_i = 32'h0001_0001;
    @(posedge clk_i); @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni = 1'b0; #1;
    check("R10 async valid_o", 32'(valid_o), 0);
    check("R10 async result_o", result_o, 0);
    check("R10 async rd_idx_o", 32'(rd_idx_o), 0);
    check("R10 async wr_en_o", 32'(wr_en_o), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule